// File: doc/BRIEF.md
# Descriptor Error Write-Back Controller

This block handles faults for a packet DMA engine that walks descriptor chains on behalf of a network MAC. It has a transmit channel and a receive channel. For each channel it watches three kinds of trouble: bus faults while the engine reads or writes descriptors, bus faults while it moves payload to or from data buffers, and (receive only) FIFO overruns. A receive overrun can also cause a bus fault, and that fault is reported on its own input.

When a payload bus fault or an overrun occurs, the controller builds two status updates. The first goes to the descriptor that was being processed when the fault hit. The second goes to the first descriptor of the packet, whose address is captured when each packet begins. Both updates leave through one request/acknowledge port as set-bits masks, so bits that are already 1 stay 1. A bus fault of any kind sets a sticky per-channel fault flag and stops the channel until software writes its start bit again. When receive stops on a fault, the receive FIFO is told to drop the packet it is unloading, provided that packet had started.

Top module: `desc_err_wb`

## Requirements
- R1: After reset both channels are halted and not running, `wb_req`, both fault flags, `err_irq` and `rx_fifo_drop` are 0.
- R2: A start write to a halted channel makes it running one cycle later. A start write to a running channel has no effect.
- R3: A payload bus fault on a running channel stops it and issues two updates with `wb_chan` = 0 for transmit and 1 for receive. The first goes to the faulting descriptor address with mask 4'b0111 and the second goes to the packet's first descriptor address with mask 4'b0011. Bit 0 marks the descriptor as touched, bit 1 means bus fault, bit 2 marks the failing descriptor and bit 3 means overrun.
- R4: A receive overrun issues mask 4'b0101 to the faulting descriptor, then mask 4'b1001 to the first descriptor. It leaves the fault flag alone, and the channel runs again right after the second acknowledge.
- R5: A descriptor bus fault, or on receive an overrun-induced bus fault, sets the channel's fault flag and halts the channel one cycle later without any write-back.
- R6: After a payload bus fault the channel reports halted only once both updates are acknowledged. It then stays halted until a start write.
- R7: A start write that arrives during a write-back is held. The channel shows halted for one cycle after the last acknowledge and then runs.
- R8: Fault flags are sticky and are cleared by a 1 on the channel's clear input. A new fault in the same cycle as a clear wins.
- R9: `err_irq` is 1 exactly when some fault flag is set while its enable input is 1.
- R10: When receive stops on a bus fault, `rx_fifo_drop` pulses for one cycle if a packet had been started (`rx_pkt_first` seen with no later `rx_pkt_done`). Otherwise it stays 0.
- R11: When both channels wait to write back, transmit is served first. While `wb_req` is 1 and unacknowledged, it stays 1 and `wb_addr`, `wb_set_bits` and `wb_chan` hold.
- R12: Fault and overrun inputs on a channel that is not running change no flag and start no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_desc_addr | input | AW | Address of descriptor being processed on transmit |
| tx_pkt_first | input | 1 | Current transmit descriptor opens a packet |
| tx_desc_err | input | 1 | Transmit descriptor bus fault |
| tx_buf_err | input | 1 | Transmit payload bus fault |
| tx_start_wr | input | 1 | Software writes the transmit start bit |
| tx_err_clr | input | 1 | Clears the transmit fault flag |
| tx_irq_en | input | 1 | Interrupt enable for transmit flag |
| rx_desc_addr | input | AW | Address of descriptor being processed on receive |
| rx_pkt_first | input | 1 | Current receive descriptor opens a packet |
| rx_pkt_done | input | 1 | Receive packet fully moved out of FIFO |
| rx_desc_err | input | 1 | Receive descriptor bus fault |
| rx_buf_err | input | 1 | Receive payload bus fault |
| rx_overflow | input | 1 | Receive FIFO overrun |
| rx_ovf_bus_err | input | 1 | Bus fault caused by a receive overrun |
| rx_start_wr | input | 1 | Software writes the receive start bit |
| rx_err_clr | input | 1 | Clears the receive fault flag |
| rx_irq_en | input | 1 | Interrupt enable for receive flag |
| wb_ack | input | 1 | Write-back accepted |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | AW | Descriptor address to update |
| wb_set_bits | output | 4 | Status bits to OR into the descriptor |
| wb_chan | output | 1 | 0 transmit, 1 receive |
| tx_running | output | 1 | Transmit channel active |
| tx_halted | output | 1 | Transmit channel stopped |
| rx_running | output | 1 | Receive channel active |
| rx_halted | output | 1 | Receive channel stopped |
| tx_err_flag | output | 1 | Sticky transmit fault flag |
| rx_err_flag | output | 1 | Sticky receive fault flag |
| err_irq | output | 1 | Error interrupt request |
| rx_fifo_drop | output | 1 | Drop the packet being unloaded from the FIFO |

## Verification
The bench builds the block with AW = 16, so that the faulting and first-descriptor addresses are short hex values. With these the two updates of each scenario, including the case where both addresses are the same, can be told apart and checked directly. The default parameters change only the address width, so nothing that depends on timing or on the masks is out of reach at this size. Holding off acknowledges for several cycles brings the stable-request rule, the pending start and the transmit-first ordering within reach.

// File: rtl/desc_err_pkg.sv
package desc_err_pkg;

  localparam int MARK_W     = 4;
  localparam int MARK_TOUCH = 0;
  localparam int MARK_BUS   = 1;
  localparam int MARK_HERE  = 2;
  localparam int MARK_OVRN  = 3;

  typedef enum logic [1:0] {
    ST_HALT     = 2'd0,
    ST_RUN      = 2'd1,
    ST_WB_FAULT = 2'd2,
    ST_WB_FIRST = 2'd3
  } chan_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_BUF  = 2'd1,
    CAUSE_OVF  = 2'd2
  } cause_e;

  // mask ORed into the descriptor where the fault hit
  function automatic logic [MARK_W-1:0] fault_mark(input cause_e c);
    logic [MARK_W-1:0] m;
    m = '0;
    case (c)
      CAUSE_BUF: begin
        m[MARK_TOUCH] = 1'b1;
        m[MARK_BUS]   = 1'b1;
        m[MARK_HERE]  = 1'b1;
      end
      CAUSE_OVF: begin
        m[MARK_TOUCH] = 1'b1;
        m[MARK_HERE]  = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

  // mask ORed into the first descriptor of the packet
  function automatic logic [MARK_W-1:0] first_mark(input cause_e c);
    logic [MARK_W-1:0] m;
    m = '0;
    case (c)
      CAUSE_BUF: begin
        m[MARK_TOUCH] = 1'b1;
        m[MARK_BUS]   = 1'b1;
      end
      CAUSE_OVF: begin
        m[MARK_TOUCH] = 1'b1;
        m[MARK_OVRN]  = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/desc_err_chan.sv
module desc_err_chan
  import desc_err_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     desc_addr,
  input  logic              pkt_first,
  input  logic              pkt_done,
  input  logic              desc_err,
  input  logic              buf_err,
  input  logic              ovf,
  input  logic              ovf_bus_err,
  input  logic              start_wr,
  input  logic              wb_ack,
  output logic              wb_req,
  output logic [AW-1:0]     wb_addr,
  output logic [MARK_W-1:0] wb_bits,
  output logic              running,
  output logic              halted,
  output logic              err_set,
  output logic              drop
);

  chan_state_e st_q, st_d;
  cause_e      cause_q, cause_d;
  logic [AW-1:0] first_q, fault_q;
  logic pkt_act_q, pend_q, drop_q;
  logic is_run, wb_busy, hard_stop;

  assign is_run    = (st_q == ST_RUN);
  assign wb_busy   = (st_q == ST_WB_FAULT) || (st_q == ST_WB_FIRST);
  assign hard_stop = desc_err | ovf_bus_err;
  assign err_set   = is_run & (hard_stop | buf_err);

  always_comb begin
    st_d    = st_q;
    cause_d = cause_q;
    case (st_q)
      ST_HALT: if (start_wr || pend_q) st_d = ST_RUN;
      ST_RUN: begin
        if (hard_stop) begin
          st_d = ST_HALT;
        end else if (buf_err) begin
          st_d    = ST_WB_FAULT;
          cause_d = CAUSE_BUF;
        end else if (ovf) begin
          st_d    = ST_WB_FAULT;
          cause_d = CAUSE_OVF;
        end
      end
      ST_WB_FAULT: if (wb_ack) st_d = ST_WB_FIRST;
      ST_WB_FIRST: if (wb_ack) st_d = (cause_q == CAUSE_OVF) ? ST_RUN : ST_HALT;
      default: st_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_HALT;
      cause_q   <= CAUSE_NONE;
      first_q   <= '0;
      fault_q   <= '0;
      pkt_act_q <= 1'b0;
      pend_q    <= 1'b0;
      drop_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      cause_q <= cause_d;
      if (is_run && pkt_first) first_q <= desc_addr;
      if (is_run && st_d == ST_WB_FAULT) fault_q <= desc_addr;
      if (err_set || pkt_done) pkt_act_q <= 1'b0;
      else if (is_run && pkt_first) pkt_act_q <= 1'b1;
      if (st_d == ST_RUN) pend_q <= 1'b0;
      else if (wb_busy && start_wr) pend_q <= 1'b1;
      drop_q <= err_set & pkt_act_q;
    end
  end

  assign wb_req  = wb_busy;
  assign wb_addr = (st_q == ST_WB_FAULT) ? fault_q : first_q;
  assign wb_bits = (st_q == ST_WB_FAULT) ? fault_mark(cause_q) : first_mark(cause_q);
  assign running = is_run;
  assign halted  = (st_q == ST_HALT);
  assign drop    = drop_q;

endmodule

// File: rtl/desc_err_arb.sv
module desc_err_arb
  import desc_err_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        req,
  input  logic [AW-1:0]     addr [2],
  input  logic [MARK_W-1:0] bits [2],
  input  logic              wb_ack,
  output logic [1:0]        gnt,
  output logic              wb_req,
  output logic [AW-1:0]     wb_addr,
  output logic [MARK_W-1:0] wb_bits,
  output logic              wb_chan
);

  logic lock_q, own_q, sel;

  // transmit (index 0) wins unless a request is already on the port
  always_comb begin
    if (lock_q) sel = own_q;
    else        sel = ~req[0];
  end

  assign wb_req  = req[sel];
  assign wb_addr = addr[sel];
  assign wb_bits = bits[sel];
  assign wb_chan = sel;
  assign gnt[0]  = wb_req & ~sel;
  assign gnt[1]  = wb_req & sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      own_q  <= 1'b0;
    end else begin
      lock_q <= wb_req & ~wb_ack;
      own_q  <= sel;
    end
  end

endmodule

// File: rtl/desc_err_flags.sv
module desc_err_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] set,
  input  logic [1:0] clr,
  input  logic [1:0] en,
  output logic [1:0] flag,
  output logic       irq
);

  logic [1:0] flag_q;

  for (genvar i = 0; i < 2; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= set[i] | (flag_q[i] & ~clr[i]);
    end
  end

  assign flag = flag_q;
  assign irq  = |(flag_q & en);

endmodule

// File: rtl/desc_err_wb.sv
module desc_err_wb
  import desc_err_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     tx_desc_addr,
  input  logic              tx_pkt_first,
  input  logic              tx_desc_err,
  input  logic              tx_buf_err,
  input  logic              tx_start_wr,
  input  logic              tx_err_clr,
  input  logic              tx_irq_en,
  input  logic [AW-1:0]     rx_desc_addr,
  input  logic              rx_pkt_first,
  input  logic              rx_pkt_done,
  input  logic              rx_desc_err,
  input  logic              rx_buf_err,
  input  logic              rx_overflow,
  input  logic              rx_ovf_bus_err,
  input  logic              rx_start_wr,
  input  logic              rx_err_clr,
  input  logic              rx_irq_en,
  input  logic              wb_ack,
  output logic              wb_req,
  output logic [AW-1:0]     wb_addr,
  output logic [MARK_W-1:0] wb_set_bits,
  output logic              wb_chan,
  output logic              tx_running,
  output logic              tx_halted,
  output logic              rx_running,
  output logic              rx_halted,
  output logic              tx_err_flag,
  output logic              rx_err_flag,
  output logic              err_irq,
  output logic              rx_fifo_drop
);

  logic [AW-1:0]     c_addr [2];
  logic [1:0]        c_first, c_done, c_derr, c_berr, c_ovf, c_obe, c_start;
  logic [1:0]        c_req, c_ack, c_run, c_halt, err_set;
  logic [AW-1:0]     c_wb_addr [2];
  logic [MARK_W-1:0] c_wb_bits [2];
  logic              c_drop [2];
  logic [1:0]        arb_gnt, flag_vec;

  assign c_addr[0] = tx_desc_addr;   assign c_addr[1] = rx_desc_addr;
  assign c_first   = {rx_pkt_first, tx_pkt_first};
  assign c_done    = {rx_pkt_done, 1'b0};
  assign c_derr    = {rx_desc_err, tx_desc_err};
  assign c_berr    = {rx_buf_err, tx_buf_err};
  assign c_ovf     = {rx_overflow, 1'b0};
  assign c_obe     = {rx_ovf_bus_err, 1'b0};
  assign c_start   = {rx_start_wr, tx_start_wr};
  assign c_ack     = arb_gnt & {2{wb_ack}};

  for (genvar i = 0; i < 2; i++) begin : g_chan
    desc_err_chan #(.AW(AW)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .desc_addr   (c_addr[i]),
      .pkt_first   (c_first[i]),
      .pkt_done    (c_done[i]),
      .desc_err    (c_derr[i]),
      .buf_err     (c_berr[i]),
      .ovf         (c_ovf[i]),
      .ovf_bus_err (c_obe[i]),
      .start_wr    (c_start[i]),
      .wb_ack      (c_ack[i]),
      .wb_req      (c_req[i]),
      .wb_addr     (c_wb_addr[i]),
      .wb_bits     (c_wb_bits[i]),
      .running     (c_run[i]),
      .halted      (c_halt[i]),
      .err_set     (err_set[i]),
      .drop        (c_drop[i])
    );
  end

  desc_err_arb #(.AW(AW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (c_req),
    .addr    (c_wb_addr),
    .bits    (c_wb_bits),
    .wb_ack  (wb_ack),
    .gnt     (arb_gnt),
    .wb_req  (wb_req),
    .wb_addr (wb_addr),
    .wb_bits (wb_set_bits),
    .wb_chan (wb_chan)
  );

  desc_err_flags u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (err_set),
    .clr   ({rx_err_clr, tx_err_clr}),
    .en    ({rx_irq_en, tx_irq_en}),
    .flag  (flag_vec),
    .irq   (err_irq)
  );

  assign tx_running   = c_run[0];
  assign rx_running   = c_run[1];
  assign tx_halted    = c_halt[0];
  assign rx_halted    = c_halt[1];
  assign tx_err_flag  = flag_vec[0];
  assign rx_err_flag  = flag_vec[1];
  // transmit has no FIFO to drop from: only the receive pulse leaves
  assign rx_fifo_drop = c_drop[1] | (c_drop[0] & 1'b0);

endmodule

// File: rtl/desc_err_wb_chk.sv
module desc_err_wb_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_running,
  input logic          tx_halted,
  input logic          tx_desc_err,
  input logic          tx_start_wr,
  input logic          tx_err_flag,
  input logic          tx_irq_en,
  input logic          rx_running,
  input logic          rx_err_flag,
  input logic          rx_err_clr,
  input logic          rx_fifo_drop,
  input logic          err_irq,
  input logic          wb_req,
  input logic          wb_ack,
  input logic [AW-1:0] wb_addr,
  input logic [3:0]    wb_set_bits,
  input logic          wb_chan,
  input logic [1:0]    gnt
);

  assert_gnt_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_addr) && $stable(wb_set_bits) && $stable(wb_chan));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_halted && tx_start_wr |=> tx_running);

  assert_desc_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_running && tx_desc_err |=> tx_halted);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_flag && !rx_err_clr |=> rx_err_flag);

  assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err_flag && tx_irq_en |-> err_irq);

  assert_drop_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_drop |-> !rx_running);

  assert_drop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_running |=> !rx_fifo_drop);

  assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_running |=> !$rose(tx_err_flag));

endmodule

bind desc_err_wb desc_err_wb_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_running   (tx_running),
  .tx_halted    (tx_halted),
  .tx_desc_err  (tx_desc_err),
  .tx_start_wr  (tx_start_wr),
  .tx_err_flag  (tx_err_flag),
  .tx_irq_en    (tx_irq_en),
  .rx_running   (rx_running),
  .rx_err_flag  (rx_err_flag),
  .rx_err_clr   (rx_err_clr),
  .rx_fifo_drop (rx_fifo_drop),
  .err_irq      (err_irq),
  .wb_req       (wb_req),
  .wb_ack       (wb_ack),
  .wb_addr      (wb_addr),
  .wb_set_bits  (wb_set_bits),
  .wb_chan      (wb_chan),
  .gnt          (arb_gnt)
);

// File: tb/test_desc_err_wb.sv
module test_desc_err_wb;

  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] d_addr [2];
  logic [1:0] pfirst = '0, derr = '0, berr = '0, swr = '0, eclr = '0, ien = '0;
  logic rx_done = 1'b0, rx_ovf = 1'b0, rx_obe = 1'b0, wb_ack = 1'b0;
  logic wb_req, wb_chan, err_irq, rx_fifo_drop;
  logic [AW-1:0] wb_addr;
  logic [3:0] wb_set_bits;
  logic [1:0] run_o, halt_o, flag_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  desc_err_wb #(.AW(AW)) i_desc_err_wb (
    .clk(clk), .rst_n(rst_n),
    .tx_desc_addr(d_addr[0]), .tx_pkt_first(pfirst[0]), .tx_desc_err(derr[0]),
    .tx_buf_err(berr[0]), .tx_start_wr(swr[0]), .tx_err_clr(eclr[0]), .tx_irq_en(ien[0]),
    .rx_desc_addr(d_addr[1]), .rx_pkt_first(pfirst[1]), .rx_pkt_done(rx_done),
    .rx_desc_err(derr[1]), .rx_buf_err(berr[1]), .rx_overflow(rx_ovf),
    .rx_ovf_bus_err(rx_obe), .rx_start_wr(swr[1]), .rx_err_clr(eclr[1]), .rx_irq_en(ien[1]),
    .wb_ack(wb_ack), .wb_req(wb_req), .wb_addr(wb_addr), .wb_set_bits(wb_set_bits),
    .wb_chan(wb_chan), .tx_running(run_o[0]), .tx_halted(halt_o[0]),
    .rx_running(run_o[1]), .rx_halted(halt_o[1]), .tx_err_flag(flag_o[0]),
    .rx_err_flag(flag_o[1]), .err_irq(err_irq), .rx_fifo_drop(rx_fifo_drop)
  );

  typedef struct packed {
    logic          ch;
    logic          ovf;
    logic [15:0]   first;
    logic [15:0]   fault;
    logic [3:0]    fbits;
    logic [3:0]    sbits;
    logic          run_after;
    logic          drop;
  } scen_t;

  // R3 payload faults, R4 overrun, same-address case last
  localparam scen_t SCEN [4] = '{
    scen_t'{1'b0, 1'b0, 16'h0100, 16'h0140, 4'b0111, 4'b0011, 1'b0, 1'b0},
    scen_t'{1'b1, 1'b0, 16'h2000, 16'h2020, 4'b0111, 4'b0011, 1'b0, 1'b1},
    scen_t'{1'b1, 1'b1, 16'h3000, 16'h3010, 4'b0101, 4'b1001, 1'b1, 1'b0},
    scen_t'{1'b0, 1'b0, 16'h0500, 16'h0500, 4'b0111, 4'b0011, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic start_ch(input int c);
    swr[c] = 1'b1; tick(); swr[c] = 1'b0;
  endtask

  task automatic clear_ch(input int c);
    eclr[c] = 1'b1; tick(); eclr[c] = 1'b0;
  endtask

  task automatic run_scen(input scen_t s);
    int c;
    c = int'(s.ch);
    if (!run_o[c]) begin
      start_ch(c);
      check("R2 start runs", run_o[c], 1);
    end
    d_addr[c] = s.first; pfirst[c] = 1'b1; tick();
    pfirst[c] = 1'b0; d_addr[c] = s.fault;
    if (s.ovf) rx_ovf = 1'b1; else berr[c] = 1'b1;
    tick();
    rx_ovf = 1'b0; berr[c] = 1'b0;
    check("R3/R4 fault req", wb_req, 1);
    check("R3/R4 fault addr", wb_addr, s.fault);
    check("R3/R4 fault bits", wb_set_bits, s.fbits);
    check("R3 chan", wb_chan, s.ch);
    check("R10 drop pulse", rx_fifo_drop, s.drop);
    check("R4/R5 flag", flag_o[c], !s.ovf);
    tick(); tick();
    check("R11 held addr", wb_addr, s.fault);
    check("R10 drop one cycle", rx_fifo_drop, 0);
    wb_ack = 1'b1; tick(); wb_ack = 1'b0;
    check("R3/R4 first addr", wb_addr, s.first);
    check("R3/R4 first bits", wb_set_bits, s.sbits);
    check("R6 not halted yet", halt_o[c], 0);
    wb_ack = 1'b1; tick(); wb_ack = 1'b0;
    check("R4/R6 after acks running", run_o[c], s.run_after);
    check("R6 after acks halted", halt_o[c], !s.run_after);
    check("R6 port idle", wb_req, 0);
    clear_ch(c);
  endtask

  initial begin
    d_addr[0] = '0; d_addr[1] = '0;
    repeat (3) tick();
    check("R1 tx halted", halt_o[0], 1);
    check("R1 rx halted", halt_o[1], 1);
    check("R1 running", run_o, 0);
    check("R1 wb_req", wb_req, 0);
    check("R1 flags", flag_o, 0);
    check("R1 irq", err_irq, 0);
    check("R1 drop", rx_fifo_drop, 0);
    rst_n = 1'b1; tick();

    for (int i = 0; i < 4; i++) run_scen(SCEN[i]);

    // R6: stays halted without a start write
    repeat (3) tick();
    check("R6 stays halted", halt_o[0], 1);

    // R12: faults on halted tx ignored
    berr[0] = 1'b1; derr[0] = 1'b1; tick(); berr[0] = 1'b0; derr[0] = 1'b0;
    tick();
    check("R12 no flag", flag_o[0], 0);
    check("R12 no req", wb_req, 0);

    // R2: start write while running has no effect
    start_ch(0);
    start_ch(0);
    check("R2 running ignored", run_o[0], 1);
    check("R2 no req", wb_req, 0);

    // R5 tx descriptor fault + R9 interrupt enable
    derr[0] = 1'b1; tick(); derr[0] = 1'b0;
    check("R5 tx halted", halt_o[0], 1);
    check("R5 tx flag", flag_o[0], 1);
    check("R5 no wb", wb_req, 0);
    check("R9 irq masked", err_irq, 0);
    ien[0] = 1'b1; #1;
    check("R9 irq enabled", err_irq, 1);
    // R8 sticky, then clear
    repeat (2) tick();
    check("R8 sticky", flag_o[0], 1);
    clear_ch(0);
    check("R8 cleared", flag_o[0], 0);
    check("R9 irq off", err_irq, 0);
    ien[0] = 1'b0;

    // R10 no drop when no packet started; R5 overrun bus fault
    rx_done = 1'b1; tick(); rx_done = 1'b0;
    rx_obe = 1'b1; eclr[1] = 1'b1; tick(); rx_obe = 1'b0; eclr[1] = 1'b0;
    check("R5 rx halted", halt_o[1], 1);
    check("R8 set wins over clear", flag_o[1], 1);
    check("R10 no drop", rx_fifo_drop, 0);
    check("R5 rx no wb", wb_req, 0);
    clear_ch(1);

    // R7 pending start during write-back
    start_ch(0);
    d_addr[0] = 16'h0700; pfirst[0] = 1'b1; tick(); pfirst[0] = 1'b0;
    berr[0] = 1'b1; tick(); berr[0] = 1'b0;
    start_ch(0);
    check("R7 still writing", wb_req, 1);
    wb_ack = 1'b1; tick(); tick(); wb_ack = 1'b0;
    check("R7 halted one cycle", halt_o[0], 1);
    tick();
    check("R7 runs after pend", run_o[0], 1);
    clear_ch(0);

    // R11 both channels fault together: transmit first
    start_ch(1);
    d_addr[0] = 16'h0800; d_addr[1] = 16'h4000; pfirst = 2'b11; tick(); pfirst = '0;
    berr = 2'b11; tick(); berr = '0;
    check("R11 tx first", wb_chan, 0);
    wb_ack = 1'b1; tick(); tick(); wb_ack = 1'b0;
    check("R11 rx next", wb_chan, 1);
    check("R11 rx req", wb_req, 1);
    check("R11 rx addr", wb_addr, 16'h4000);
    wb_ack = 1'b1; tick(); tick(); wb_ack = 1'b0;
    check("R11 both halted", halt_o, 2'b11);
    check("R11 port idle", wb_req, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule